// File: doc/BRIEF.md
# Page-Level ECC Result Aggregator

This block sits after a per-sector error-correction decoder in a flash page-read path. The decoder finishes one 512-byte sector at a time. For each sector it reports the sector index, the number of bits it corrected and whether the sector could not be corrected. The aggregator turns these sector results into one status for the whole page. The status is built from five parts:

- a packed word holding one 5-bit count per sector;
- the largest count seen on the page;
- three sticky flags: corrected, uncorrectable and over-threshold;
- an indication that the page looks erased rather than damaged;
- two interrupt pulses, one for the first threshold event and one for the first fatal event.

A one-cycle pulse on `page_start` clears all state and opens a new page. The page closes once every sector has reported. After that, further sector results have no effect until the next `page_start`. The correction strength and the warning threshold are configuration inputs, and software holds them steady during a page. The default of four sectors matches a 2048-byte page.

Top module: `ecc_page_status`

## Requirements
- R1: While reset is asserted and after it is released, all outputs are zero and the page is closed (`page_open` = 0).
- R2: A `page_start` pulse clears every count, flag and the maximum, and opens the page from the next cycle. A sector result presented in the same cycle as `page_start` is ignored.
- R3: An accepted result for sector i appears in `packed_counts` bits 5i+4 down to 5i in the cycle after it is presented.
- R4: `cfg_strength` encodes strength as strength/2 − 1 in 3 bits, covering even strengths 2 to 16. A sector whose raw count exceeds the strength is treated as uncorrectable even without `sec_uncorr`.
- R5: An uncorrectable sector stores the count 31 and sets `page_status` bit 1. The first such sector of a page produces a one-cycle `irq_fatal` pulse, in the same cycle as the flag.
- R6: A correctable sector with a nonzero count sets `page_status` bit 0 (at least one correction occurred).
- R7: A stored count strictly greater than the 4-bit `cfg_threshold` sets `page_status` bit 2. The first such count of a page produces a one-cycle `irq_threshold` pulse.
- R8: `max_count` equals the largest stored count among the sectors of the current page, not the count of the last sector.
- R9: Only the first result for each sector index is accepted. `page_open` falls once all sectors have reported, and results that arrive while the page is closed change nothing.
- R10: `erased_page` is 1 when all three of the following hold:
  - the page is complete;
  - every sector reported a raw count of 1 (the packed pattern 0x8421 for four sectors);
  - the uncorrectable flag is set.
- R11: The status flags stay set until the next `page_start`, whatever results follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| page_start | input | 1 | One-cycle pulse: clear state and open a new page |
| sec_valid | input | 1 | A sector result is presented this cycle |
| sec_idx | input | 2 | Index of the reporting sector |
| sec_count | input | 5 | Bits corrected in that sector |
| sec_uncorr | input | 1 | Decoder could not correct that sector |
| cfg_strength | input | 3 | Correction strength code, strength/2 − 1 |
| cfg_threshold | input | 4 | Warning threshold for per-sector counts |
| packed_counts | output | 20 | Per-sector counts, sector i at bits 5i+4:5i |
| max_count | output | 5 | Largest stored count on the page |
| page_status | output | 3 | [2] over threshold, [1] uncorrectable, [0] corrected |
| page_open | output | 1 | Page accepting sector results |
| erased_page | output | 1 | Page looks erased rather than failed |
| irq_threshold | output | 1 | Pulse on the first over-threshold sector of a page |
| irq_fatal | output | 1 | Pulse on the first uncorrectable sector of a page |

## Verification
All state is held in registers that feed the outputs directly. A corrupted count, flag or sector mask therefore shows at the ports in the cycle after the faulty update. A bad count shows in `packed_counts` or `max_count`. A bad flag shows in `page_status`. A bad mask shows as a wrong `page_open` edge or as a duplicate result being accepted. The erased-page tracker is hidden until the last sector of a page arrives. A fault there shows as a wrong `erased_page` only when the page closes, so pages are run with all-ones counts, with one deviating count and without the uncorrectable flag.

// File: rtl/ecc_agg_pkg.sv
package ecc_agg_pkg;

  // Classification of one incoming sector result.
  typedef struct packed {
    logic uncorr;     // effective uncorrectable (decoder flag or over strength)
    logic corrected;  // correctable with at least one flipped bit
    logic over;       // stored count above the warning threshold
    logic sig;        // raw count equals the erased-page field value
  } sec_class_t;

  // Status vector bit positions.
  localparam int ST_CORR = 0;
  localparam int ST_UNC  = 1;
  localparam int ST_OVER = 2;

endpackage

// File: rtl/ecc_sector_eval.sv
module ecc_sector_eval
  import ecc_agg_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int STR_W     = 3,
  parameter int THR_W     = 4,
  parameter int SIG_FIELD = 1
) (
  input  logic [CNT_W-1:0] raw_count,
  input  logic             raw_uncorr,
  input  logic [STR_W-1:0] strength_code,
  input  logic [THR_W-1:0] threshold,
  output logic [CNT_W-1:0] store_count,
  output sec_class_t       cls
);

  localparam int LIM_W = CNT_W + 1;

  logic [LIM_W-1:0] limit;
  logic             eff_unc;

  always_comb begin
    limit       = LIM_W'((32'(strength_code) + 32'd1) * 32'd2);
    eff_unc     = raw_uncorr | (LIM_W'(raw_count) > limit);
    store_count = eff_unc ? {CNT_W{1'b1}} : raw_count;
    cls.uncorr    = eff_unc;
    cls.corrected = ~eff_unc & (raw_count != '0);
    cls.over      = LIM_W'(store_count) > LIM_W'(threshold);
    cls.sig       = raw_count == CNT_W'(SIG_FIELD);
  end

endmodule

// File: rtl/ecc_count_store.sv
module ecc_count_store #(
  parameter int SECTORS = 4,
  parameter int CNT_W   = 5,
  localparam int IDX_W  = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [CNT_W-1:0]         wr_count,
  output logic [SECTORS*CNT_W-1:0] packed_q,
  output logic [SECTORS-1:0]       got_q
);

  for (genvar g = 0; g < SECTORS; g++) begin : g_sec
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             got_r, got_d;
    logic             en;

    always_comb begin
      en    = clr | (wr_en & (wr_idx == IDX_W'(g)));
      cnt_d = clr ? '0 : wr_count;
      got_d = ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        got_r <= 1'b0;
      end else if (en) begin
        cnt_q <= cnt_d;
        got_r <= got_d;
      end
    end

    assign packed_q[g*CNT_W +: CNT_W] = cnt_q;
    assign got_q[g]                   = got_r;
  end

endmodule

// File: rtl/ecc_page_flags.sv
module ecc_page_flags
  import ecc_agg_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  sec_class_t       cls,
  input  logic [CNT_W-1:0] store_count,
  output logic [2:0]       status,
  output logic [CNT_W-1:0] max_q,
  output logic             sig_q,
  output logic             irq_thr_q,
  output logic             irq_fat_q
);

  logic             unc_q, corr_q, over_q;
  logic             unc_d, corr_d, over_d, sig_d;
  logic [CNT_W-1:0] max_d;
  logic             irq_thr_d, irq_fat_d;
  logic             flag_en;

  always_comb begin
    flag_en   = clr | upd;
    unc_d     = unc_q;
    corr_d    = corr_q;
    over_d    = over_q;
    sig_d     = sig_q;
    max_d     = max_q;
    irq_thr_d = 1'b0;
    irq_fat_d = 1'b0;
    if (clr) begin
      unc_d  = 1'b0;
      corr_d = 1'b0;
      over_d = 1'b0;
      sig_d  = 1'b1;
      max_d  = '0;
    end else if (upd) begin
      unc_d     = unc_q | cls.uncorr;
      corr_d    = corr_q | cls.corrected;
      over_d    = over_q | cls.over;
      sig_d     = sig_q & cls.sig;
      max_d     = (store_count > max_q) ? store_count : max_q;
      irq_thr_d = cls.over & ~over_q;
      irq_fat_d = cls.uncorr & ~unc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unc_q  <= 1'b0;
      corr_q <= 1'b0;
      over_q <= 1'b0;
      sig_q  <= 1'b0;
      max_q  <= '0;
    end else if (flag_en) begin
      unc_q  <= unc_d;
      corr_q <= corr_d;
      over_q <= over_d;
      sig_q  <= sig_d;
      max_q  <= max_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_thr_q <= 1'b0;
      irq_fat_q <= 1'b0;
    end else begin
      irq_thr_q <= irq_thr_d;
      irq_fat_q <= irq_fat_d;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_CORR] = corr_q;
    status[ST_UNC]  = unc_q;
    status[ST_OVER] = over_q;
  end

endmodule

// File: rtl/ecc_page_status.sv
module ecc_page_status
  import ecc_agg_pkg::*;
#(
  parameter int SECTORS   = 4,
  parameter int CNT_W     = 5,
  parameter int STR_W     = 3,
  parameter int THR_W     = 4,
  parameter int SIG_FIELD = 1,
  localparam int IDX_W    = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     page_start,
  input  logic                     sec_valid,
  input  logic [IDX_W-1:0]         sec_idx,
  input  logic [CNT_W-1:0]         sec_count,
  input  logic                     sec_uncorr,
  input  logic [STR_W-1:0]         cfg_strength,
  input  logic [THR_W-1:0]         cfg_threshold,
  output logic [SECTORS*CNT_W-1:0] packed_counts,
  output logic [CNT_W-1:0]         max_count,
  output logic [2:0]               page_status,
  output logic                     page_open,
  output logic                     erased_page,
  output logic                     irq_threshold,
  output logic                     irq_fatal
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic [CNT_W-1:0]   store_count;
  sec_class_t         cls;
  logic [SECTORS-1:0] got_mask, got_after;
  logic               idx_ok, accept, open_q, open_d, open_en;
  logic               sig_ok;

  ecc_sector_eval #(
    .CNT_W(CNT_W), .STR_W(STR_W), .THR_W(THR_W), .SIG_FIELD(SIG_FIELD)
  ) u_eval (
    .raw_count    (sec_count),
    .raw_uncorr   (sec_uncorr),
    .strength_code(cfg_strength),
    .threshold    (cfg_threshold),
    .store_count  (store_count),
    .cls          (cls)
  );

  always_comb begin
    idx_ok    = 32'(sec_idx) < SECTORS;
    accept    = sec_valid & open_q & ~page_start & idx_ok & ~got_mask[sec_idx];
    got_after = got_mask | (SECTORS'(1) << sec_idx);
    open_en   = page_start | accept;
    open_d    = page_start ? 1'b1 : ~(&got_after);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  open_q <= 1'b0;
    else if (open_en) open_q <= open_d;
  end

  ecc_count_store #(.SECTORS(SECTORS), .CNT_W(CNT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clr     (page_start),
    .wr_en   (accept),
    .wr_idx  (sec_idx),
    .wr_count(store_count),
    .packed_q(packed_counts),
    .got_q   (got_mask)
  );

  ecc_page_flags #(.CNT_W(CNT_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .clr        (page_start),
    .upd        (accept),
    .cls        (cls),
    .store_count(store_count),
    .status     (page_status),
    .max_q      (max_count),
    .sig_q      (sig_ok),
    .irq_thr_q  (irq_threshold),
    .irq_fat_q  (irq_fatal)
  );

  assign page_open   = open_q;
  assign erased_page = ~open_q & (&got_mask) & sig_ok & page_status[ST_UNC];

endmodule

// File: rtl/ecc_page_status_chk.sv
module ecc_page_status_chk #(
  parameter int SECTORS = 4,
  parameter int CNT_W   = 5
) (
  input logic                     clk,
  input logic                     rst_core_n,
  input logic                     page_start,
  input logic [SECTORS*CNT_W-1:0] packed_counts,
  input logic [CNT_W-1:0]         max_count,
  input logic [2:0]               page_status,
  input logic                     page_open,
  input logic                     erased_page,
  input logic                     irq_threshold,
  input logic                     irq_fatal
);

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    page_start |=> (packed_counts == '0 && page_status == 3'b000 && page_open));

  // R5
  unc_max_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    page_status[1] |-> (max_count == {CNT_W{1'b1}}));

  // R5
  fatal_irq_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq_fatal |-> page_status[1]);

  // R7
  thr_irq_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq_threshold |-> page_status[2]);

  // R9
  closed_frozen_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!page_open && !page_start) |=> $stable(packed_counts) && $stable(page_status));

  // R10
  erased_closed_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    erased_page |-> (page_status[1] && !page_open));

  // R11
  sticky_unc_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (page_status[1] && !page_start) |=> page_status[1]);

  for (genvar i = 0; i < SECTORS; i++) begin : g_max
    // R8
    max_bound_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
      max_count >= packed_counts[i*CNT_W +: CNT_W]);
  end

endmodule

bind ecc_page_status ecc_page_status_chk #(.SECTORS(SECTORS), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_core_n   (rst_core_n),
  .page_start   (page_start),
  .packed_counts(packed_counts),
  .max_count    (max_count),
  .page_status  (page_status),
  .page_open    (page_open),
  .erased_page  (erased_page),
  .irq_threshold(irq_threshold),
  .irq_fatal    (irq_fatal)
);

// File: tb/ecc_page_status_bench.sv
module ecc_page_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SECTORS = 4;
  localparam int CNT_W = 5;
  localparam int IDX_W = 2;
  localparam int STR_W = 3;
  localparam int THR_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic page_start = 1'b0, sec_valid = 1'b0, sec_uncorr = 1'b0;
  logic [IDX_W-1:0] sec_idx = '0;
  logic [CNT_W-1:0] sec_count = '0;
  logic [STR_W-1:0] cfg_strength = '0;
  logic [THR_W-1:0] cfg_threshold = '0;
  logic [SECTORS*CNT_W-1:0] packed_counts;
  logic [CNT_W-1:0] max_count;
  logic [2:0] page_status;
  logic page_open, erased_page, irq_threshold, irq_fatal;

  ecc_page_status u_ecc_page_status (
    .clk(clk), .rst_n(rst_n), .page_start(page_start), .sec_valid(sec_valid),
    .sec_idx(sec_idx), .sec_count(sec_count), .sec_uncorr(sec_uncorr),
    .cfg_strength(cfg_strength), .cfg_threshold(cfg_threshold),
    .packed_counts(packed_counts), .max_count(max_count), .page_status(page_status),
    .page_open(page_open), .erased_page(erased_page),
    .irq_threshold(irq_threshold), .irq_fatal(irq_fatal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  string tag = "R1 reset";
  bit compare_en = 1'b0;

  // Behavioural reference
  int m_cnt[SECTORS];
  bit m_got[SECTORS];
  bit m_open, m_unc, m_corr, m_over, m_sig, m_it, m_if;
  int m_max;

  task automatic model_clear(bit opn);
    for (int i = 0; i < SECTORS; i++) begin m_cnt[i] = 0; m_got[i] = 0; end
    m_open = opn; m_unc = 0; m_corr = 0; m_over = 0; m_sig = 1;
    m_max = 0; m_it = 0; m_if = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_clear(1'b0);
    else begin
      m_it = 0; m_if = 0;
      if (page_start) model_clear(1'b1);
      else if (sec_valid && m_open && !m_got[sec_idx]) begin
        int raw, st, strength;
        bit unc, all;
        raw = int'(sec_count);
        strength = 2 * (int'(cfg_strength) + 1);
        unc = sec_uncorr || (raw > strength);
        st = unc ? 31 : raw;
        if (raw != 1) m_sig = 0;
        m_got[sec_idx] = 1;
        m_cnt[sec_idx] = st;
        if (unc) begin if (!m_unc) m_if = 1; m_unc = 1; end
        else if (st > 0) m_corr = 1;
        if (st > int'(cfg_threshold)) begin if (!m_over) m_it = 1; m_over = 1; end
        if (st > m_max) m_max = st;
        all = 1;
        for (int i = 0; i < SECTORS; i++) if (!m_got[i]) all = 0;
        if (all) m_open = 0;
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s]: actual %0h expected %0h", req, tag, act, exp);
    end
  endtask

  function automatic bit m_erased();
    bit all = 1;
    for (int i = 0; i < SECTORS; i++) if (!m_got[i]) all = 0;
    return !m_open && all && m_sig && m_unc;
  endfunction

  always @(negedge clk) begin
    if (compare_en) begin
      logic [SECTORS*CNT_W-1:0] e = '0;
      for (int i = 0; i < SECTORS; i++) e[i*CNT_W +: CNT_W] = CNT_W'(m_cnt[i]);
      chk("R3", 64'(packed_counts), 64'(e));
      chk("R8", 64'(max_count), 64'(m_max));
      chk("R6", 64'(page_status[0]), 64'(m_corr));
      chk("R5", 64'(page_status[1]), 64'(m_unc));
      chk("R7", 64'(page_status[2]), 64'(m_over));
      chk("R9", 64'(page_open), 64'(m_open));
      chk("R10", 64'(erased_page), 64'(m_erased()));
      chk("R5", 64'(irq_fatal), 64'(m_if));
      chk("R7", 64'(irq_threshold), 64'(m_it));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send(int idx, int cnt, bit unc);
    @(negedge clk); #1;
    sec_valid = 1; sec_idx = IDX_W'(idx); sec_count = CNT_W'(cnt); sec_uncorr = unc;
    @(negedge clk); #1;
    sec_valid = 0; sec_uncorr = 0; sec_count = '0;
  endtask

  task automatic start_page();
    @(negedge clk); #1; page_start = 1;
    @(negedge clk); #1; page_start = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog [%s]: actual hung expected done", tag);
    finish_run();
  end

  initial begin
    // R1: outputs during and after reset
    idle(3);
    chk("R1", 64'({packed_counts, max_count, page_status, page_open, erased_page,
                   irq_threshold, irq_fatal}), 64'(0));
    rst_n = 1;
    idle(4);
    chk("R1", 64'({packed_counts, max_count, page_status, page_open}), 64'(0));
    compare_en = 1;

    // Result while closed after reset is ignored
    tag = "R9 closed after reset";
    send(1, 3, 0);

    tag = "R3 R8 R6 R7 mixed page";
    cfg_strength = 3'd3; cfg_threshold = 4'd5;
    start_page();
    send(2, 3, 0); send(0, 0, 0); send(3, 6, 0);
    tag = "R11 flags held";
    send(1, 2, 0);
    @(negedge clk);
    chk("R11", 64'(page_status), 64'(3'b101));
    chk("R8", 64'(max_count), 64'(6));
    tag = "R9 after close";
    send(0, 7, 1);
    send(1, 4, 0);

    tag = "R2 start with result";
    @(negedge clk); #1;
    page_start = 1; sec_valid = 1; sec_idx = 2'd1; sec_count = 5'd4;
    @(negedge clk); #1;
    page_start = 0; sec_valid = 0;
    @(negedge clk);
    chk("R2", 64'(packed_counts), 64'(0));

    tag = "R9 duplicate R5 uncorr";
    send(1, 2, 0); send(1, 5, 0);
    send(0, 4, 1);
    tag = "R11 sticky unc";
    send(2, 0, 0); send(3, 1, 0);
    @(negedge clk);
    chk("R11", 64'(page_status[1]), 64'(1));

    tag = "R4 strength limit";
    cfg_strength = 3'd0; cfg_threshold = 4'd15;
    start_page();
    send(0, 2, 0); send(1, 3, 0);
    @(negedge clk);
    chk("R4", 64'(page_status[1]), 64'(1));
    send(2, 0, 0); send(3, 0, 0);

    tag = "R7 threshold 15 strength 16";
    cfg_strength = 3'd7; cfg_threshold = 4'd15;
    start_page();
    send(3, 15, 0); send(0, 16, 0); send(1, 17, 0); send(2, 8, 0);

    tag = "R10 erased signature";
    start_page();
    for (int i = 0; i < SECTORS; i++) send(i, 1, 1);
    @(negedge clk);
    chk("R10", 64'(erased_page), 64'(1));

    tag = "R10 near-erased";
    start_page();
    send(0, 1, 1); send(1, 1, 1); send(2, 2, 1); send(3, 1, 1);

    tag = "R10 ones without uncorr";
    start_page();
    for (int i = 0; i < SECTORS; i++) send(i, 1, 0);

    tag = "R2 abort mid-page";
    cfg_threshold = 4'd2;
    start_page();
    send(0, 3, 0);
    start_page();
    @(negedge clk);
    chk("R2", 64'({page_status, page_open}), 64'(1));
    send(3, 9, 0); send(2, 0, 0); send(1, 1, 0); send(0, 2, 0);

    idle(3);
    finish_run();
  end

endmodule